// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is a serial slave that takes 16-bit command words from a host controller over a four-wire serial link. It works in mode 0: the serial clock rests low and each data bit is taken on the rising clock edge. It runs entirely in the system clock domain. The serial clock, chip select and data input pass through two-flop synchronizers. Serial clock edges are then found by comparing successive synchronized samples.

Each word starts when chip select goes low. The first four bits received form an opcode and the remaining twelve an operand, most significant bit first. One opcode writes the operand into a twelve-bit mode register. Another opcode switches an internal trace flag on or off. Every register write raises a strobe for one system clock. A decoded flag reports when the mode register holds the value meaning "off". Downstream logic uses that flag to go idle with the antenna disabled.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, mode_q is 12'h000, trace_en is 0, mode_stb and trace_stb are 0, and antenna_off is 1.
- R2: A word is the first 16 bits sampled on rising sck edges while cs_n is low, most significant bit first. Bits 15..12 are the opcode and bits 11..0 are the operand.
- R3: Opcode 4'h1 loads the operand into mode_q and pulses mode_stb for exactly one clock, even when the value does not change.
- R4: Opcode 4'h2 with operand 12'h001 sets trace_en, and with operand 12'h000 clears it, each with a one-clock trace_stb pulse. Any other operand leaves trace_en unchanged and gives no strobe.
- R5: antenna_off is 1 exactly when mode_q equals 12'h000, so writing mode 0 puts the logic into the idle, antenna-off state.
- R6: If cs_n rises before 16 bits have arrived, the partial word is dropped and no register or strobe changes.
- R7: Every falling edge of cs_n restarts the bit count, so a full word sent after a dropped partial word decodes correctly.
- R8: Opcodes other than 4'h1 and 4'h2 change no register and raise no strobe.
- R9: Bits after the sixteenth within one chip-select frame are ignored.
- R10: mode_q and trace_en change only in a clock where their own strobe is high, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Active-low chip select framing one word |
| mosi | input | 1 | Serial data from host |
| mode_q | output | 12 | Mode configuration register |
| trace_en | output | 1 | Internal trace enable flag |
| mode_stb | output | 1 | One-clock pulse on a mode register write |
| trace_stb | output | 1 | One-clock pulse on a trace flag write |
| antenna_off | output | 1 | High while the mode register holds the off value |

## Verification
A wrong bit count or a misaligned shift register shows at the ports as a wrong opcode or operand in the clock right after the sixteenth synchronized rising edge. It appears as a missing strobe, a strobe on the wrong register, or a rotated operand in mode_q. Random frames of random length are mixed with directed truncated, over-long and unknown-opcode frames. Each frame is checked within a few clocks of chip select rising. Counting strobe pulses over each frame shows a stuck or repeated strobe at the first frame it affects.

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int WORD_W = 16,
  parameter int OP_W = 4,
  parameter logic [OP_W-1:0] OP_MODE = 4'h1,
  parameter logic [OP_W-1:0] OP_TRACE = 4'h2,
  parameter logic [WORD_W-OP_W-1:0] MODE_OFF = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     cs_n,
  input  logic                     mosi,
  output logic [WORD_W-OP_W-1:0]   mode_q,
  output logic                     trace_en,
  output logic                     mode_stb,
  output logic                     trace_stb,
  output logic                     antenna_off
);
  localparam int ARG_W = WORD_W - OP_W;
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [2:0]        sck_sy;
  logic [1:0]        cs_sy, mosi_sy;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-2:0] shreg;

  wire sck_rise = sck_sy[1] & ~sck_sy[2];
  wire cs_act   = ~cs_sy[1];
  wire [WORD_W-1:0] word = {shreg, mosi_sy[1]};
  wire [OP_W-1:0]   op   = word[WORD_W-1 -: OP_W];
  wire [ARG_W-1:0]  arg  = word[ARG_W-1:0];
  wire last_bit = cs_act & sck_rise & (cnt == LAST);
  wire wr_mode  = last_bit & (op == OP_MODE);
  wire wr_trace = last_bit & (op == OP_TRACE) & (arg == '0 || arg == ARG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck};
      cs_sy   <= {cs_sy[0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (!cs_act) begin
      cnt <= '0;
    end else if (sck_rise && cnt != FULL) begin
      cnt   <= cnt + 1'b1;
      shreg <= word[WORD_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      trace_en  <= 1'b0;
      mode_stb  <= 1'b0;
      trace_stb <= 1'b0;
    end else begin
      mode_stb  <= wr_mode;
      trace_stb <= wr_trace;
      if (wr_mode)  mode_q   <= arg;
      if (wr_trace) trace_en <= arg[0];
    end
  end

  assign antenna_off = (mode_q == MODE_OFF);

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_stb, trace_stb}));
  assert_mode_only_on_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> mode_stb);
  assert_trace_only_on_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trace_en) |-> trace_stb);
  assert_mode_stb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stb |=> !mode_stb);
  assert_trace_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trace_stb |=> !trace_stb);
  assert_no_write_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !(mode_stb || trace_stb));
endmodule

// File: tb/tb_spi_cmd_rx.sv
module tb_spi_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic [11:0] mode_q;
  logic trace_en, mode_stb, trace_stb, antenna_off;

  int checks = 0, errors = 0;
  int mstb_cnt = 0, tstb_cnt = 0;
  logic [11:0] exp_mode = 12'h000;
  logic exp_trace = 1'b0;

  spi_cmd_rx dut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .mode_q(mode_q), .trace_en(trace_en), .mode_stb(mode_stb),
    .trace_stb(trace_stb), .antenna_off(antenna_off));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mode_stb) mstb_cnt++;
    if (trace_stb) tstb_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_mode_wr(input logic [15:0] w, input int n);
    return n >= 16 && w[15:12] == 4'h1;
  endfunction

  function automatic bit exp_trace_wr(input logic [15:0] w, input int n);
    return n >= 16 && w[15:12] == 4'h2 && (w[11:0] == 12'h000 || w[11:0] == 12'h001);
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int n, input logic [15:0] extra);
    cs_n = 0;
    waitc(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : extra[i % 16];
      waitc(HALF);
      sck = 1;
      waitc(HALF);
      sck = 0;
    end
    waitc(HALF);
    cs_n = 1;
    waitc(HALF + 4);
  endtask

  task automatic frame(input logic [15:0] w, input int n, input logic [15:0] extra, input string tag);
    int m0, t0, em, et;
    m0 = mstb_cnt; t0 = tstb_cnt;
    em = exp_mode_wr(w, n) ? 1 : 0;
    et = exp_trace_wr(w, n) ? 1 : 0;
    if (em == 1) exp_mode = w[11:0];
    if (et == 1) exp_trace = w[0];
    send(w, n, extra);
    chk(mode_q == exp_mode, {tag, " mode_q"}, int'(mode_q), int'(exp_mode));
    chk(trace_en == exp_trace, {tag, " trace_en"}, int'(trace_en), int'(exp_trace));
    chk(mstb_cnt - m0 == em, {tag, " mode_stb pulses"}, mstb_cnt - m0, em);
    chk(tstb_cnt - t0 == et, {tag, " trace_stb pulses"}, tstb_cnt - t0, et);
    chk(antenna_off == (exp_mode == 12'h000), {tag, " R5 antenna_off"},
        int'(antenna_off), int'(exp_mode == 12'h000));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    waitc(3);
    chk(mode_q == 12'h000 && trace_en == 0 && mode_stb == 0 && trace_stb == 0 && antenna_off == 1,
        "R1 reset state", int'({mode_q, trace_en, antenna_off}), int'({12'h000, 1'b0, 1'b1}));
    rst_n = 1;
    waitc(3);
    frame(16'h1A5C, 16, 16'h0, "R2 R3 mode write");
    frame(16'h1A5C, 16, 16'h0, "R3 same-value write");
    frame(16'h2001, 16, 16'h0, "R4 trace on");
    frame(16'h2005, 16, 16'h0, "R4 odd operand ignored");
    frame(16'h2000, 16, 16'h0, "R4 trace off");
    frame(16'h1000, 16, 16'h0, "R5 mode off");
    frame(16'h1123, 16, 16'h0, "R5 mode on");
    frame(16'h1FFF, 9, 16'h0, "R6 truncated");
    frame(16'h1FFF, 15, 16'h0, "R6 fifteen bits");
    frame(16'h1777, 16, 16'h0, "R7 after partial");
    frame(16'h3ABC, 16, 16'h0, "R8 opcode 3");
    frame(16'hF001, 16, 16'h0, "R8 opcode F");
    frame(16'h1456, 24, 16'hFFFF, "R9 over-long");
    frame(16'h2001, 20, 16'h0000, "R9 over-long trace");
    for (int k = 0; k < 150; k++) begin
      logic [15:0] w;
      int n, sel;
      sel = $urandom_range(0, 9);
      w = 16'($urandom);
      if (sel < 4) w[15:12] = 4'h1;
      else if (sel < 7) begin
        w[15:12] = 4'h2;
        if ($urandom_range(0, 3) != 0) w[11:0] = 12'($urandom_range(0, 1));
      end
      n = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 22) : 16;
      frame(w, n, 16'($urandom), "R2 R10 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule